// File: doc/BRIEF.md
# Network controller interrupt status and mask unit

This block gathers single-cycle event pulses from the transmit, receive, DMA and pin-monitor logic of a network controller. Each event sets a bit in a 16-bit sticky status register. A 16-bit enable mask gates the status bits onto one level-sensitive interrupt line to the host.

Software uses a simple strobe-based register port. It reads the status register to learn which event caused an interrupt, and it writes ones to clear the bits it has handled. A 16-bit tally counts CRC-error and packet-race events; when it wraps, it raises its own status bit so that software can keep a wider count. A change on the link-report pin is recorded only while the general-purpose pin enable is high.

Top module: `nic_irq_unit`

## Requirements
- R1: After reset the status register, the mask register and the tally all read 0, and `irq_o` is low.
- R2: A high event input sets its status bit at the clock edge that samples it. The bit map is: 0 receive good, 1 transmit good, 2 receive error, 3 transmit abort (excessive collisions), 4 transmit underflow, 5 no receive buffer, 6 bus error, 7 tally wrap, 8 first buffer filled, 9 link pin change, 10 receive FIFO overflow, 11 packet race, 12 port status change, 13 wake-key received.
- R3: A write to the status register (byte offset 0x0C) clears every bit whose write-data bit is 1 within an enabled byte lane. Zero bits and disabled lanes leave their bits unchanged. `reg_be_i[0]` covers bits 7:0 and `reg_be_i[1]` covers bits 15:8.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask register (offset 0x0E) loads only the enabled byte lanes. Reads return the stored value.
- R6: `irq_o` is high exactly when some status bit and its mask bit are both 1. It falls in the cycle after the last enabled bit is cleared, and status bits with mask 0 never raise it.
- R7: Status bit 2 is set by any one of a CRC error, an alignment error or a missed frame.
- R8: A level change on `link_pin_i` sets status bit 9 only while `gpio_en_i` is 1. A change made while it is 0 is ignored.
- R9: The tally adds one for each cycle in which a CRC error or a packet race is flagged. After 65535 it wraps to 0 and sets status bit 7.
- R10: A read of offset 0x10 returns the tally and clears it. An event in the same cycle leaves the count at 1.
- R11: Read data appears on `reg_rdata_o` one cycle after the read strobe. Status and mask bits 15:14 read 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_be_i | input | 2 | Byte-lane enables for writes |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| ev_rx_ok_i | input | 1 | Frame received without error |
| ev_tx_ok_i | input | 1 | Frame sent without error |
| ev_rx_crc_i | input | 1 | Received frame with CRC error |
| ev_rx_align_i | input | 1 | Received frame with alignment error |
| ev_rx_missed_i | input | 1 | Frame missed |
| ev_tx_abort_i | input | 1 | Transmit aborted on excessive collisions |
| ev_tx_ufl_i | input | 1 | Transmit buffer underflow |
| ev_rx_nobuf_i | input | 1 | No receive buffer available |
| ev_bus_err_i | input | 1 | Host bus error |
| ev_first_buf_i | input | 1 | First receive buffer filled |
| ev_fifo_ovf_i | input | 1 | Receive FIFO overflow |
| ev_pkt_race_i | input | 1 | Next frame raced into FIFO |
| ev_port_chg_i | input | 1 | Port status change |
| ev_wake_key_i | input | 1 | Wake-key frame received |
| link_pin_i | input | 1 | General-purpose link-report pin |
| gpio_en_i | input | 1 | Enables link-pin change detection |
| irq_o | output | 1 | Level interrupt to host |

## Verification
An event pulse driven before a rising edge shows in the status register after that edge, and `irq_o` follows in the same cycle because it is combinational from the status and mask flops. A read issued at one edge delivers its data after the next edge. The bench drives every input at a falling edge. It queues each expected read value and compares it at the following falling edge, one rising edge after the strobe. Interrupt-line checks are made at the falling edge just after the write or event that should change the line.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned LANES  = REG_W / 8;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h0E;
  localparam logic [ADDR_W-1:0] OFS_TALLY = 8'h10;

  localparam int unsigned B_RX_OK     = 0;
  localparam int unsigned B_TX_OK     = 1;
  localparam int unsigned B_RX_ERR    = 2;
  localparam int unsigned B_TX_ERR    = 3;
  localparam int unsigned B_TX_UFL    = 4;
  localparam int unsigned B_RX_NOBUF  = 5;
  localparam int unsigned B_BUS_ERR   = 6;
  localparam int unsigned B_TALLY_OVF = 7;
  localparam int unsigned B_FIRST_BUF = 8;
  localparam int unsigned B_LINK      = 9;
  localparam int unsigned B_FIFO_OVF  = 10;
  localparam int unsigned B_PKT_RACE  = 11;
  localparam int unsigned B_PORT_CHG  = 12;
  localparam int unsigned B_WAKE_KEY  = 13;

  localparam logic [REG_W-1:0] IMPL_BITS = 16'h3FFF;

  typedef struct packed {
    logic wake_key;
    logic port_chg;
    logic pkt_race;
    logic fifo_ovf;
    logic first_buf;
    logic bus_err;
    logic rx_nobuf;
    logic tx_ufl;
    logic tx_abort;
    logic rx_missed;
    logic rx_align;
    logic rx_crc;
    logic tx_ok;
    logic rx_ok;
  } nic_evt_t;
endpackage

// File: rtl/nic_irq_evt.sv
module nic_irq_evt
  import nic_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  nic_evt_t         evt_i,
  input  logic             link_pin_i,
  input  logic             gpio_en_i,
  output logic [REG_W-1:0] set_o,
  output logic             tally_inc_o
);
  logic link_q;
  logic link_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= 1'b0;
    else         link_q <= link_pin_i;
  end

  assign link_chg = link_pin_i ^ link_q;

  always_comb begin
    set_o              = '0;
    set_o[B_RX_OK]     = evt_i.rx_ok;
    set_o[B_TX_OK]     = evt_i.tx_ok;
    set_o[B_RX_ERR]    = evt_i.rx_crc | evt_i.rx_align | evt_i.rx_missed;
    set_o[B_TX_ERR]    = evt_i.tx_abort;
    set_o[B_TX_UFL]    = evt_i.tx_ufl;
    set_o[B_RX_NOBUF]  = evt_i.rx_nobuf;
    set_o[B_BUS_ERR]   = evt_i.bus_err;
    set_o[B_FIRST_BUF] = evt_i.first_buf;
    set_o[B_LINK]      = link_chg & gpio_en_i;
    set_o[B_FIFO_OVF]  = evt_i.fifo_ovf;
    set_o[B_PKT_RACE]  = evt_i.pkt_race;
    set_o[B_PORT_CHG]  = evt_i.port_chg;
    set_o[B_WAKE_KEY]  = evt_i.wake_key;
  end

  // one count per cycle, even when both sources fire together
  assign tally_inc_o = evt_i.rx_crc | evt_i.pkt_race;
endmodule

// File: rtl/nic_irq_tally.sv
module nic_irq_tally #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = inc_i && !rd_clr_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (rd_clr_i) cnt_q <= CNT_W'(inc_i);
    else if (inc_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
  import nic_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  input  logic [LANES-1:0] mask_we_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] mask_o
);
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] mask_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= ((status_q & ~clr_i) | set_i) & IMPL_BITS;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_q[l*8 +: 8] <= '0;
      else if (mask_we_i[l]) mask_q[l*8 +: 8] <= mask_wdata_i[l*8 +: 8] & IMPL_BITS[l*8 +: 8];
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [LANES-1:0]  reg_be_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ev_rx_ok_i,
  input  logic              ev_tx_ok_i,
  input  logic              ev_rx_crc_i,
  input  logic              ev_rx_align_i,
  input  logic              ev_rx_missed_i,
  input  logic              ev_tx_abort_i,
  input  logic              ev_tx_ufl_i,
  input  logic              ev_rx_nobuf_i,
  input  logic              ev_bus_err_i,
  input  logic              ev_first_buf_i,
  input  logic              ev_fifo_ovf_i,
  input  logic              ev_pkt_race_i,
  input  logic              ev_port_chg_i,
  input  logic              ev_wake_key_i,
  input  logic              link_pin_i,
  input  logic              gpio_en_i,
  output logic              irq_o
);
  nic_evt_t         evt;
  logic [REG_W-1:0] evt_set;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] lane_bits;
  logic [LANES-1:0] mask_we;
  logic [REG_W-1:0] status_q;
  logic [REG_W-1:0] mask_q;
  logic [CNT_W-1:0] tally_q;
  logic             tally_inc;
  logic             tally_rd;
  logic             tally_wrap;
  logic             hit_stat;
  logic             hit_mask;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    evt.rx_ok     = ev_rx_ok_i;
    evt.tx_ok     = ev_tx_ok_i;
    evt.rx_crc    = ev_rx_crc_i;
    evt.rx_align  = ev_rx_align_i;
    evt.rx_missed = ev_rx_missed_i;
    evt.tx_abort  = ev_tx_abort_i;
    evt.tx_ufl    = ev_tx_ufl_i;
    evt.rx_nobuf  = ev_rx_nobuf_i;
    evt.bus_err   = ev_bus_err_i;
    evt.first_buf = ev_first_buf_i;
    evt.fifo_ovf  = ev_fifo_ovf_i;
    evt.pkt_race  = ev_pkt_race_i;
    evt.port_chg  = ev_port_chg_i;
    evt.wake_key  = ev_wake_key_i;
  end

  nic_irq_evt u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .link_pin_i  (link_pin_i),
    .gpio_en_i   (gpio_en_i),
    .set_o       (evt_set),
    .tally_inc_o (tally_inc)
  );

  assign tally_rd = reg_rd_i && (reg_addr_i == OFS_TALLY);

  nic_irq_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tally_inc),
    .rd_clr_i (tally_rd),
    .cnt_o    (tally_q),
    .wrap_o   (tally_wrap)
  );

  always_comb begin
    set_vec              = evt_set;
    set_vec[B_TALLY_OVF] = tally_wrap;
  end

  assign hit_stat = reg_wr_i && (reg_addr_i == OFS_STAT);
  assign hit_mask = reg_wr_i && (reg_addr_i == OFS_MASK);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l*8 +: 8] = {8{reg_be_i[l]}};
    assign mask_we[l]          = hit_mask & reg_be_i[l];
  end

  assign clr_vec = hit_stat ? (reg_wdata_i & lane_bits) : '0;

  nic_irq_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_vec),
    .clr_i        (clr_vec),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i),
    .status_o     (status_q),
    .mask_o       (mask_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (reg_rd_i) begin
      case (reg_addr_i)
        OFS_STAT:  rdata_q <= status_q;
        OFS_MASK:  rdata_q <= mask_q;
        OFS_TALLY: rdata_q <= REG_W'(tally_q);
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = |(status_q & mask_q);
endmodule

// File: rtl/nic_irq_sva.sv
module nic_irq_sva
  import nic_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [LANES-1:0]  reg_be_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              gpio_en_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  set_vec,
  input logic [REG_W-1:0]  status_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [CNT_W-1:0]  tally_q,
  input logic              tally_inc,
  input logic              tally_rd
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_w1c_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFS_STAT && reg_be_i == '1 && reg_wdata_i == '1 && set_vec == '0)
    |=> status_q == '0);

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == OFS_MASK) |=> $stable(mask_q));

  p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o);

  p_gpio_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gpio_en_i && !status_q[B_LINK]) |=> !status_q[B_LINK]);

  p_tally_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tally_inc && !tally_rd && tally_q == CNT_MAX) |=> (tally_q == '0 && status_q[B_TALLY_OVF]));

  p_tally_rdclr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tally_rd && !tally_inc) |=> tally_q == '0);
endmodule

bind nic_irq_unit nic_irq_sva #(.CNT_W(CNT_W)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_be_i    (reg_be_i),
  .reg_wdata_i (reg_wdata_i),
  .gpio_en_i   (gpio_en_i),
  .irq_o       (irq_o),
  .set_vec     (set_vec),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .tally_q     (tally_q),
  .tally_inc   (tally_inc),
  .tally_rd    (tally_rd)
);

// File: tb/sim_nic_irq_unit.sv
module sim_nic_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [13:0] ev = '0;
  logic        link = 1'b0;
  logic        gpio = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  nic_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_be_i(be), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ev_rx_ok_i(ev[0]), .ev_tx_ok_i(ev[1]), .ev_rx_crc_i(ev[2]), .ev_rx_align_i(ev[3]),
    .ev_rx_missed_i(ev[4]), .ev_tx_abort_i(ev[5]), .ev_tx_ufl_i(ev[6]), .ev_rx_nobuf_i(ev[7]),
    .ev_bus_err_i(ev[8]), .ev_first_buf_i(ev[9]), .ev_fifo_ovf_i(ev[10]), .ev_pkt_race_i(ev[11]),
    .ev_port_chg_i(ev[12]), .ev_wake_key_i(ev[13]),
    .link_pin_i(link), .gpio_en_i(gpio), .irq_o(irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd;

  // monitor: read data due one rising edge after the strobe
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic rd_exp(input logic [7:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    addr = a; wdata = d; be = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic pulse(input logic [13:0] v);
    @(negedge clk);
    ev = v;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk({15'd0, irq}, 16'h0, "R1 irq after reset");
    rd_exp(8'h0C, 16'h0000, "R1 status after reset");
    rd_exp(8'h0E, 16'h0000, "R1 mask after reset");
    rd_exp(8'h10, 16'h0000, "R1 tally after reset");

    pulse(14'h0001);
    rd_exp(8'h0C, 16'h0001, "R2 rx good");
    pulse(14'h0002);
    rd_exp(8'h0C, 16'h0003, "R2 tx good");
    pulse(14'h34C0);
    rd_exp(8'h0C, 16'h3433, "R2 multi events");
    chk({15'd0, irq}, 16'h0, "R6 masked status no irq");
    wr_reg(8'h0C, 16'hFFFF, 2'b11);
    rd_exp(8'h0C, 16'h0000, "R3 clear all");

    pulse(14'h0300);
    rd_exp(8'h0C, 16'h0140, "R2 bus err first buf");
    wr_reg(8'h0C, 16'hFFFF, 2'b01);
    rd_exp(8'h0C, 16'h0100, "R3 low lane only");
    wr_reg(8'h0C, 16'h0000, 2'b11);
    rd_exp(8'h0C, 16'h0100, "R3 zeros keep");
    wr_reg(8'h0C, 16'hFFFF, 2'b10);
    rd_exp(8'h0C, 16'h0000, "R3 high lane");

    pulse(14'h0004);
    rd_exp(8'h0C, 16'h0004, "R7 crc");
    wr_reg(8'h0C, 16'h0004, 2'b11);
    pulse(14'h0008);
    rd_exp(8'h0C, 16'h0004, "R7 align");
    wr_reg(8'h0C, 16'h0004, 2'b11);
    pulse(14'h0010);
    rd_exp(8'h0C, 16'h0004, "R7 missed");
    wr_reg(8'h0C, 16'h0004, 2'b11);
    pulse(14'h0020);
    rd_exp(8'h0C, 16'h0008, "R2 tx abort");
    wr_reg(8'h0C, 16'h0008, 2'b11);

    // R4: set and clear in the same cycle
    @(negedge clk);
    ev = 14'h0001; addr = 8'h0C; wdata = 16'h0001; be = 2'b11; wr = 1'b1;
    @(negedge clk);
    ev = '0; wr = 1'b0; be = '0;
    rd_exp(8'h0C, 16'h0001, "R4 set wins");

    wr_reg(8'h0E, 16'hFFFF, 2'b10);
    rd_exp(8'h0E, 16'h3F00, "R5 mask high lane");
    chk({15'd0, irq}, 16'h0, "R6 bit0 masked");
    wr_reg(8'h0E, 16'h00FF, 2'b01);
    chk({15'd0, irq}, 16'h1, "R6 irq on enable");
    rd_exp(8'h0E, 16'h3FFF, "R11 mask reserved bits");
    wr_reg(8'h0C, 16'h0001, 2'b11);
    chk({15'd0, irq}, 16'h0, "R6 irq falls after clear");

    @(negedge clk); link = 1'b1;
    repeat (3) @(negedge clk);
    chk({15'd0, irq}, 16'h0, "R8 change ignored irq");
    rd_exp(8'h0C, 16'h0000, "R8 change ignored status");
    gpio = 1'b1;
    repeat (2) @(negedge clk);
    link = 1'b0;
    @(negedge clk);
    chk({15'd0, irq}, 16'h1, "R8 change seen irq");
    rd_exp(8'h0C, 16'h0200, "R8 change seen status");
    wr_reg(8'h0C, 16'hFFFF, 2'b11);

    rd_exp(8'h10, 16'h0001, "R10 tally read");
    rd_exp(8'h10, 16'h0000, "R10 tally cleared");
    pulse(14'h0804);
    pulse(14'h0800);
    rd_exp(8'h10, 16'h0002, "R9 one per cycle");
    rd_exp(8'h10, 16'h0000, "R10 cleared again");
    wr_reg(8'h0C, 16'hFFFF, 2'b11);

    @(negedge clk); ev = 14'h0800;
    repeat (65535) @(negedge clk);
    ev = '0;
    rd_exp(8'h0C, 16'h0800, "R9 no wrap at max");
    pulse(14'h0800);
    chk({15'd0, irq}, 16'h1, "R9 wrap irq");
    rd_exp(8'h0C, 16'h0880, "R9 wrap status");
    rd_exp(8'h10, 16'h0000, "R9 wrapped to zero");
    rd_exp(8'h20, 16'h0000, "R11 unmapped");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all-req act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule